// File: doc/BRIEF.md
# Comma Detector and Word Aligner

This block takes a serial stream that has already been cut into 10-bit words by a deserializer. The cut is at an arbitrary bit position, and the block restores the true symbol boundary. It keeps the two most recent words as a 20-bit window and tests all ten bit offsets of that window for a comma at the same time. When it finds one, it latches the winning offset as a one-hot select. From then on, every word it emits is the 10-bit slice at that offset, ready for a 10b/8b decoder.

The first bit received on the line is bit 0 of each input word. The window is `{current word, previous word}`, so window bit 0 is the earliest bit in the window. The slice at offset i is window bits [i+9:i]. The same ordering holds for the output word: bit 0 is the earliest bit of the symbol.

Top module: `comma_aligner`

## Requirements
- R1: After reset, `out_valid` and `det` are 0 and `lock_sel` is all zeros.
- R2: A slice is a comma when its seven earliest bits (slice bits [6:0]), read from bit 0 upward, are 0,0,1,1,1,1,1, or the complement 1,1,0,0,0,0,0. Both polarities are detected.
- R3: `lock_sel` is one-hot or zero, and bit i set means the symbol boundary is at window offset i.
- R4: When several offsets hold a comma in the same window, the lowest offset is latched.
- R5: `out_valid` stays 0 until the first comma has been detected.
- R6: A comma whose first bit lies in the word accepted at one valid edge is emitted as an aligned word at the second valid edge after that one. Each later valid edge emits the next 10 stream bits at the latched offset.
- R7: `det` pulses for one cycle after each accepted word whose window holds a comma at any offset.
- R8: Once an offset is latched and `realign_en` is 0, a comma at the same offset or at any other offset leaves `lock_sel` and the output alignment unchanged.
- R9: With `realign_en` at 1, a comma at a different offset moves `lock_sel` to the new offset. The word emitted at that edge already uses the new offset.
- R10: A cycle with `realign_req` at 1 clears `lock_sel`, `out_valid` and `det`. The next comma is then acquired as on a first detection.
- R11: A cycle with `in_valid` at 0 emits nothing (`out_valid` and `det` are 0) and leaves the window and `lock_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | W | Unaligned input word, bit 0 earliest |
| in_valid | input | 1 | Input word strobe |
| realign_en | input | 1 | Allow a comma at a new offset to move the lock |
| realign_req | input | 1 | Drop the current lock |
| out_word | output | W | Aligned symbol, bit 0 earliest |
| out_valid | output | 1 | Aligned symbol strobe |
| det | output | 1 | Comma seen in the last accepted window |
| lock_sel | output | W | One-hot latched boundary offset |

## Verification
The bench builds the block with its default word width of 10 and comma length of 7. With these values every offset from 0 to 9 is reachable from a short bit stream. This includes the two edge offsets, where the slice lies wholly in one word or straddles almost all of the next word. It also allows two commas of opposite polarity to sit in the same 20-bit window, which exercises the lowest-offset rule. Streams are built bit by bit, so the expected aligned words come straight from the stream positions. They do not depend on the design's internal pipeline.

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int W = 10,
  parameter int CLEN = 7,
  parameter logic [CLEN-1:0] COMMA = 7'b1111100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_word,
  input  logic         in_valid,
  input  logic         realign_en,
  input  logic         realign_req,
  output logic [W-1:0] out_word,
  output logic         out_valid,
  output logic         det,
  output logic [W-1:0] lock_sel
);
  localparam int WIN = 2 * W;

  logic [W-1:0]   cur_q, prev_q;
  logic [1:0]     fill_q;
  logic [WIN-1:0] win;
  logic [W-1:0]   hit, pick, next_sel, mux_word;
  logic           full, trig, take;

  assign full = fill_q[1];
  assign win  = {cur_q, prev_q};

  for (genvar i = 0; i < W; i++) begin : g_det
    logic [W-1:0] slice;
    assign slice  = win[i +: W];
    assign hit[i] = full && ((slice[CLEN-1:0] == COMMA) || (slice[CLEN-1:0] == ~COMMA));
  end

  assign pick = hit & (~hit + 1'b1);
  assign trig = |hit;
  assign take = trig && ((lock_sel == '0) || (realign_en && (pick != lock_sel)));
  assign next_sel = take ? pick : lock_sel;

  always_comb begin
    mux_word = '0;
    for (int i = 0; i < W; i++)
      if (next_sel[i]) mux_word = mux_word | win[i +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q     <= '0;
      prev_q    <= '0;
      fill_q    <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
      det       <= 1'b0;
      lock_sel  <= '0;
    end else begin
      det       <= in_valid && trig && !realign_req;
      out_valid <= in_valid && !realign_req && (next_sel != '0);
      if (in_valid) begin
        cur_q  <= in_word;
        prev_q <= cur_q;
        fill_q <= {fill_q[0], 1'b1};
        if (next_sel != '0) out_word <= mux_word;
      end
      if (realign_req)   lock_sel <= '0;
      else if (in_valid) lock_sel <= next_sel;
    end
  end

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_sel));

  p_valid_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lock_sel != '0));

  p_det_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det |-> (lock_sel != '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_sel != '0) && !realign_en && !realign_req) |=> (lock_sel == $past(lock_sel)));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    realign_req |=> ((lock_sel == '0) && !out_valid && !det));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !det));
endmodule

// File: tb/sim_comma_aligner.sv
`timescale 1ns/1ps
module sim_comma_aligner;
  localparam int W = 10;
  localparam int NW = 64;
  localparam logic [9:0] SYM_P = 10'b0101111100;
  localparam logic [9:0] SYM_N = 10'b1010000011;

  logic clk = 1'b0;
  logic rst_n, in_valid, realign_en, realign_req;
  logic [W-1:0] in_word, out_word, lock_sel;
  logic out_valid, det;

  int errs = 0, checks = 0;
  bit done = 0;

  logic strm [0:NW*W-1];
  logic         ov [0:NW-1];
  logic         dt [0:NW-1];
  logic [W-1:0] ow [0:NW-1];
  logic [W-1:0] ls [0:NW-1];

  always #2 clk = ~clk;

  comma_aligner u0 (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .realign_en(realign_en), .realign_req(realign_req), .out_word(out_word),
    .out_valid(out_valid), .det(det), .lock_sel(lock_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] bits_at(input int pos);
    logic [W-1:0] v;
    for (int j = 0; j < W; j++) v[j] = strm[pos + j];
    return v;
  endfunction

  task automatic put_sym(input int pos, input logic [9:0] s);
    for (int j = 0; j < W; j++) strm[pos + j] = s[j];
  endtask

  task automatic do_reset();
    for (int i = 0; i < NW*W; i++) strm[i] = ~i[0];
    rst_n = 0; in_valid = 0; realign_en = 0; realign_req = 0; in_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(input int n, input int rq_at, input int gap_at, input int gap_len, input logic ren);
    for (int w = 0; w < n; w++) begin
      if (w == gap_at) begin
        for (int g = 0; g < gap_len; g++) begin
          in_valid = 0; realign_req = 0;
          @(negedge clk);
          chk(!out_valid && !det, "R11 idle emits nothing", {out_valid, det}, 0);
          chk(lock_sel == ls[w-1], "R11 lock held in idle", lock_sel, ls[w-1]);
        end
      end
      in_word = bits_at(w * W); in_valid = 1; realign_en = ren;
      realign_req = (w == rq_at);
      @(negedge clk);
      ov[w] = out_valid; ow[w] = out_word; ls[w] = lock_sel; dt[w] = det;
    end
    in_valid = 0; realign_req = 0;
    @(negedge clk);
  endtask

  task automatic expect_none(input int lo, input int hi, input string req);
    for (int w = lo; w <= hi; w++) begin
      chk(ov[w] == 0, req, ov[w], 0);
      chk(ls[w] == 0, req, ls[w], 0);
    end
  endtask

  task automatic expect_seg(input int lo, input int hi, input int s, input string req);
    for (int w = lo; w <= hi; w++) begin
      chk(ov[w] == 1, req, ov[w], 1);
      chk(ls[w] == (W'(1) << s), req, ls[w], W'(1) << s);
      chk(ow[w] == bits_at(W*(w-2) + s), req, ow[w], bits_at(W*(w-2) + s));
    end
  endtask

  task automatic expect_det(input int lo, input int hi, input int e1, input int e2, input string req);
    for (int w = lo; w <= hi; w++)
      chk(dt[w] == ((w == e1) || (w == e2)), req, dt[w], (w == e1) || (w == e2));
  endtask

  task automatic t_reset();
    do_reset();
    chk(!out_valid && !det, "R1 reset strobes", {out_valid, det}, 0);
    chk(lock_sel == 0, "R1 reset lock", lock_sel, 0);
  endtask

  task automatic t_no_comma();
    do_reset();
    run(12, -1, -1, 0, 0);
    expect_none(0, 11, "R5 no comma no valid");
    expect_det(0, 11, -1, -1, "R7 no comma no det");
  endtask

  task automatic t_offset(input int p, input logic [9:0] sym, input string req);
    do_reset();
    put_sym(p, sym);
    run(12, -1, -1, 0, 0);
    expect_none(0, p/W + 1, "R5 before detect");
    expect_seg(p/W + 2, 11, p % W, req);
    chk(ow[p/W + 2] == sym, "R6 first word is comma", ow[p/W + 2], sym);
    expect_det(0, 11, p/W + 2, -1, "R7 single det");
  endtask

  task automatic t_lowest();
    do_reset();
    put_sym(20, SYM_P);
    put_sym(27, SYM_N);
    run(10, -1, -1, 0, 0);
    expect_seg(4, 9, 0, "R4 lowest offset wins");
    expect_det(0, 9, 4, -1, "R7 det with two commas");
  endtask

  task automatic t_hold_same();
    do_reset();
    put_sym(23, SYM_P);
    put_sym(63, SYM_P);
    run(12, -1, -1, 0, 0);
    expect_seg(4, 11, 3, "R8 same offset kept");
    expect_det(0, 11, 4, 8, "R7 det on repeat comma");
  endtask

  task automatic t_other(input logic ren);
    do_reset();
    put_sym(23, SYM_P);
    put_sym(66, SYM_P);
    run(12, -1, -1, 0, ren);
    if (!ren) expect_seg(4, 11, 3, "R8 other offset ignored");
    else begin
      expect_seg(4, 7, 3, "R9 before move");
      expect_seg(8, 11, 6, "R9 moved to new offset");
    end
    expect_det(0, 11, 4, 8, "R7 det on other offset");
  endtask

  task automatic t_realign();
    do_reset();
    put_sym(23, SYM_P);
    put_sym(85, SYM_N);
    run(14, 6, -1, 0, 0);
    expect_seg(4, 5, 3, "R10 before request");
    expect_none(6, 9, "R10 cleared after request");
    expect_seg(10, 13, 5, "R10 reacquired");
    expect_det(0, 13, 4, 10, "R10 det after reacquire");
  endtask

  task automatic t_gap();
    do_reset();
    put_sym(23, SYM_P);
    run(12, -1, 7, 3, 0);
    expect_seg(4, 11, 3, "R11 stream resumes aligned");
  endtask

  initial begin
    #400000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_no_comma();
    t_offset(23, SYM_P, "R6 offset 3 aligned");
    t_offset(20, SYM_P, "R2 offset 0");
    t_offset(29, SYM_P, "R2 offset 9");
    t_offset(35, SYM_N, "R2 complement offset 5");
    t_lowest();
    t_hold_same();
    t_other(1'b0);
    t_other(1'b1);
    t_realign();
    t_gap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule